// File: doc/BRIEF.md
# Multi-Channel PWM DAC Bank

This block holds a bank of independent 8-bit pulse-width modulators. Each channel drives one output whose duty cycle is set by a byte register. The registers are written and read over a simple register bus. All channels share one period counter, so their pulses start on the same clock. After external low-pass filtering, each output serves as a slow analog control voltage.

A single select input picks the period length: 256 clocks, or 253 clocks. In the 253-clock mode the three largest codes saturate to a steady high level. In the 256-clock mode full scale still leaves one low clock in every period. A channel-enable mask forces individual outputs low. Register writes are double-buffered. A new code, and a new period select, take effect only at the start of the next period, so a pulse is never cut short or stretched.

Top module: `pwm_bank`

## Requirements
- R1: Bus addresses 0 to NUM_CH-1 each select one channel's 8-bit code register. A write to any higher address changes no register, and a read from one returns 00h.
- R2: One shared counter runs from 0 up to the period length minus one and then wraps to 0. The period length is 256 clocks while the latched mode is 0 and 253 clocks while it is 1. The mode input is latched at each wrap.
- R3: In the 253-clock mode, an enabled channel with code FDh, FEh or FFh stays high on every clock.
- R4: In the 256-clock mode, an enabled channel with code FFh is high for 255 clocks and low for exactly one clock in each period. The low clock is the last one.
- R5: Code 00h keeps the output low on every clock in both modes.
- R6: An enabled channel is high exactly while the counter is below its active code. A period therefore starts with `code` high clocks, capped at the period length.
- R7: After reset, every code register and active code holds 80h, the counter is 0 and the latched mode is the 256-clock mode.
- R8: A written code becomes the active code at the wrap that follows the write. A write made in the wrap cycle itself is included. Until then the output follows the old code.
- R9: While a channel's enable bit is 0 its output is low whatever its code. Its register still accepts writes and reads.
- R10: A read returns, combinationally from the address, the last value written to that channel. The read is valid from the clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the PWM time base |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Channel register address |
| bus_wdata | input | 8 | Write data (duty code) |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| short_period | input | 1 | 1 selects the 253-clock period, 0 the 256-clock period |
| ch_enable | input | NUM_CH | Per-channel enable mask |
| pwm_out | output | NUM_CH | Per-channel PWM outputs |

## Verification
A write lands in the code register at the clock edge that samples it, so the read data shows it one edge later. The output moves to the new code only at the wrap edge after that. A change on `short_period` also waits for a wrap, while `ch_enable` acts on the output at once with no register in the path.

The bench keeps a behavioural model built from integers and arrays. The model advances on the same rising edges as the design. The bench compares every output and the read data on each falling edge, so each result is checked in exactly the cycle it falls due. Directed period measurements then start at a model-predicted wrap and count high clocks over one whole period for the saturation, zero, disable and mode cases.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
    localparam int CODE_W = 8;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CODE_W-1:0] cnt_t;
endpackage

// File: rtl/pwm_period_gen.sv
module pwm_period_gen
    import pwm_bank_pkg::*;
#(
    parameter int PERIOD_LONG  = 256,
    parameter int PERIOD_SHORT = 253
) (
    input  logic clk,
    input  logic rst_n,
    input  logic short_sel,
    output cnt_t cnt,
    output logic wrap,
    output logic mode_short
);
    localparam cnt_t TOP_LONG  = cnt_t'(PERIOD_LONG - 1);
    localparam cnt_t TOP_SHORT = cnt_t'(PERIOD_SHORT - 1);

    typedef struct packed {
        cnt_t cnt;
        logic mode_short;
    } state_t;

    state_t st_d, st_q;
    cnt_t   top;
    logic   wrap_d;

    always_comb begin
        st_d   = st_q;
        top    = st_q.mode_short ? TOP_SHORT : TOP_LONG;
        wrap_d = (st_q.cnt == top);
        if (wrap_d) begin
            st_d.cnt        = '0;
            st_d.mode_short = short_sel;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt        = st_q.cnt;
    assign wrap       = wrap_d;
    assign mode_short = st_q.mode_short;

    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> (cnt == cnt_t'($past(cnt) + 1'b1)));
    a_r2_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(mode_short));
    a_r2_short_bound: assert property (@(posedge clk) disable iff (!rst_n)
        mode_short |-> (cnt <= TOP_SHORT));
endmodule

// File: rtl/pwm_reg_file.sv
module pwm_reg_file
    import pwm_bank_pkg::*;
#(
    parameter int    NUM_CH     = 14,
    parameter int    ADDR_W     = 4,
    parameter code_t RESET_CODE = 8'h80
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  code_t                         wdata,
    input  logic                          wrap,
    output code_t                         rdata,
    output logic [NUM_CH-1:0][CODE_W-1:0] active
);
    typedef struct packed {
        logic [NUM_CH-1:0][CODE_W-1:0] shadow;
        logic [NUM_CH-1:0][CODE_W-1:0] active;
    } regs_t;

    regs_t rg_d, rg_q;
    logic  addr_ok;

    assign addr_ok = (int'(addr) < NUM_CH);

    always_comb begin
        rg_d = rg_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (wr_en && addr_ok && (int'(addr) == i)) begin
                rg_d.shadow[i] = wdata;
            end
        end
        if (wrap) begin
            rg_d.active = rg_d.shadow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                rg_q.shadow[i] <= RESET_CODE;
                rg_q.active[i] <= RESET_CODE;
            end
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr_ok && (int'(addr) == i)) begin
                rdata = rg_q.shadow[i];
            end
        end
    end

    assign active = rg_q.active;

    a_r8_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(rg_q.active));
    a_r8_active_load: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (rg_q.active == rg_q.shadow));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_wchk
        a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && int'(addr) == g) |=> (rg_q.shadow[g] == $past(wdata)));
        a_r1_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && int'(addr) == g) |=> $stable(rg_q.shadow[g]));
    end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_bank_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  code_t code,
    input  logic  enable,
    input  cnt_t  cnt,
    input  logic  mode_short,
    output logic  pwm
);
    logic below;

    always_comb begin
        below = (cnt < code);
        pwm   = enable && below;
    end

    a_r5_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (code == '0) |-> !pwm);
    a_r9_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !pwm);
    a_r3_short_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && mode_short && code >= 8'hFD) |-> pwm);
    a_r4_long_full_dips: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !mode_short && code == 8'hFF && cnt == 8'hFF) |-> !pwm);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH       = 14,
    parameter int ADDR_W       = 4,
    parameter int PERIOD_LONG  = 256,
    parameter int PERIOD_SHORT = 253
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              short_period,
    input  logic [NUM_CH-1:0] ch_enable,
    output logic [NUM_CH-1:0] pwm_out
);
    cnt_t                          cnt;
    logic                          wrap;
    logic                          mode_short;
    logic [NUM_CH-1:0][CODE_W-1:0] active;

    pwm_period_gen #(
        .PERIOD_LONG (PERIOD_LONG),
        .PERIOD_SHORT(PERIOD_SHORT)
    ) u_period (
        .clk       (clk),
        .rst_n     (rst_n),
        .short_sel (short_period),
        .cnt       (cnt),
        .wrap      (wrap),
        .mode_short(mode_short)
    );

    pwm_reg_file #(
        .NUM_CH    (NUM_CH),
        .ADDR_W    (ADDR_W),
        .RESET_CODE(8'h80)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .wrap  (wrap),
        .rdata (bus_rdata),
        .active(active)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .code      (active[g]),
            .enable    (ch_enable[g]),
            .cnt       (cnt),
            .mode_short(mode_short),
            .pwm       (pwm_out[g])
        );
    end
endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 14;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wr = 1'b0;
    logic [3:0]     bus_addr = '0;
    logic [7:0]     bus_wdata = '0;
    logic [7:0]     bus_rdata;
    logic           short_period = 1'b0;
    logic [NCH-1:0] ch_enable = '1;
    logic [NCH-1:0] pwm_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    int m_cnt, m_mode;
    int m_shadow[NCH];
    int m_active[NCH];
    int hc[NCH];
    int plen;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .short_period(short_period),
        .ch_enable(ch_enable), .pwm_out(pwm_out)
    );

    // Behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0;
            m_mode = 0;
            for (int i = 0; i < NCH; i++) begin
                m_shadow[i] = 128;
                m_active[i] = 128;
            end
        end else begin
            if (bus_wr && int'(bus_addr) < NCH) m_shadow[bus_addr] = int'(bus_wdata);
            if (m_cnt == (m_mode != 0 ? 252 : 255)) begin
                m_cnt = 0;
                m_mode = int'(short_period);
                for (int i = 0; i < NCH; i++) m_active[i] = m_shadow[i];
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    end

    task automatic check_eq(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model (R2, R6, R8, R9, R10)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < NCH; i++) begin
                check_eq(int'(pwm_out[i]),
                         (ch_enable[i] && m_cnt < m_active[i]) ? 1 : 0,
                         $sformatf("R6 cycle ch%0d", i));
            end
            check_eq(int'(bus_rdata),
                     int'(bus_addr) < NCH ? m_shadow[bus_addr] : 0, "R10 cycle rdata");
        end
    end

    task automatic bus_write(input int a, input int d);
        @(negedge clk); #1;
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 8'(d);
        @(negedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic read_chk(input int a, input int exp, input string tag);
        @(negedge clk); #1;
        bus_addr = 4'(a);
        @(negedge clk);
        check_eq(int'(bus_rdata), exp, tag);
    endtask

    // Count high clocks per channel over one full period, starting at a wrap
    task automatic measure_period();
        do @(negedge clk); while (m_cnt != 0);
        plen = 0;
        for (int i = 0; i < NCH; i++) hc[i] = 0;
        do begin
            for (int i = 0; i < NCH; i++) hc[i] += int'(pwm_out[i]);
            plen++;
            @(negedge clk);
        end while (m_cnt != 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state visible at ports
        check_eq(int'(pwm_out), (1 << NCH) - 1, "R7 outputs high at count 0 with code 80h");
        #1 rst_n = 1'b1;
        for (int a = 0; a < NCH; a++) read_chk(a, 128, "R7 reset code");
        measure_period();
        check_eq(plen, 256, "R7 R2 default period 256");
        check_eq(hc[5], 128, "R7 80h gives 128 high clocks");

        // R8: new codes wait for the wrap
        bus_write(0, 'hFF);
        bus_write(1, 'h00);
        bus_write(2, 'h40);
        bus_write(3, 'hFD);
        bus_write(4, 'hFE);
        bus_write(5, 'h01);
        read_chk(0, 'hFF, "R10 readback ch0");
        read_chk(2, 'h40, "R10 readback ch2");
        measure_period();
        check_eq(plen, 256, "R2 long period");
        check_eq(hc[0], 255, "R4 FFh one low clock");
        check_eq(hc[1], 0, "R5 00h low in long mode");
        check_eq(hc[2], 64, "R6 40h width");
        check_eq(hc[3], 253, "R6 FDh long mode width");
        check_eq(hc[5], 1, "R6 01h width");

        // R2/R3: short period mode
        short_period = 1'b1;
        measure_period();
        measure_period();
        check_eq(plen, 253, "R2 short period");
        check_eq(hc[0], 253, "R3 FFh saturates high");
        check_eq(hc[3], 253, "R3 FDh saturates high");
        check_eq(hc[4], 253, "R3 FEh saturates high");
        check_eq(hc[1], 0, "R5 00h low in short mode");
        check_eq(hc[2], 64, "R6 40h width short mode");

        // R9: disabled channel low, register still live
        ch_enable[2] = 1'b0;
        ch_enable[0] = 1'b0;
        bus_write(2, 'h90);
        measure_period();
        check_eq(hc[2], 0, "R9 disabled ch2 low");
        check_eq(hc[0], 0, "R9 disabled saturated ch0 low");
        read_chk(2, 'h90, "R9 disabled register writable");
        ch_enable = '1;
        measure_period();
        check_eq(hc[2], 144, "R9 re-enabled uses new code");

        // R1: out-of-range address
        bus_write(14, 'h11);
        bus_write(15, 'h22);
        read_chk(15, 0, "R1 out-of-range read 00h");
        read_chk(13, 128, "R1 ch13 untouched");
        read_chk(0, 'hFF, "R1 ch0 untouched");

        // Back to long mode, FFh dips again
        short_period = 1'b0;
        measure_period();
        measure_period();
        check_eq(plen, 256, "R2 back to long period");
        check_eq(hc[0], 255, "R4 FFh dip after mode return");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule